// File: doc/BRIEF.md
# Thermal Threshold Throttling Monitor

This block supervises die temperature. Every clock it registers a 7-bit sensor sample in whole degrees Celsius. It compares the sample against three programmable limits: a warning limit, a critical limit and a trip limit. From the result it produces a 2-bit throttle command and a fatal shutdown request for an external board controller. The warning and critical limits each have their own enable bit. A policy bit chooses whether reaching the warning limit requests light or heavy throttling.

Software talks to the block over a plain register bus: a write strobe, a read strobe, a byte address and 64-bit data. Three locations are mapped:

- **Limit register (offset 0x08).** Holds the programmed limits and the live alarm bits.
- **Sensor readout (offset 0x10).** Returns the registered temperature.
- **Capability word (offset 0x20).** Reports a strap input. When the strap is set, all automatic throttling is suppressed.

Top module: `thermal_mon_top`

## Requirements
- R1: After a synchronous reset, every field of the limit register reads 0, the throttle output is 0 and the fatal output is 0.
- R2: A write to offset 0x08 updates the following fields. Warning limit in bits 6:0, with its enable in bit 7. Critical limit in bits 14:8, with its enable in bit 15. Trip limit in bits 30:24. Policy in bit 44. The alarm bits 32 and 33 are read-only, and writes to them are ignored. All other bits are ignored and read 0.
- R3: Bit 32 of offset 0x08 reads 1 exactly when the warning enable is set and the temperature is at or above the warning limit. Bit 33 does the same for the critical enable and the critical limit.
- R4: While the critical alarm is active and throttling is permitted, the throttle output is 3 (full throttling).
- R5: While only the warning alarm is active, the throttle output is 1 when the policy bit is 1 (50%) and 2 when the policy bit is 0 (90%). With no alarm active it is 0.
- R6: A limit whose enable bit is clear never sets its alarm bit and never affects the throttle output.
- R7: The fatal output is 1 while the trip limit is nonzero and the temperature is at or above it. Otherwise it is 0.
- R8: A trip limit of 0 disables the fatal output at every temperature.
- R9: Offset 0x10 returns the registered temperature in bits 6:0, with every other bit 0.
- R10: Offset 0x20 bit 0 reflects the no-throttle strap. While the strap is 1, the throttle output stays 0, and the alarm bits and the fatal output behave as usual.
- R11: Reads from any unmapped offset return 0. Writes to any offset other than 0x08 change nothing.
- R12: Read data appears on the clock edge after the read strobe. The throttle and fatal outputs follow a sensor change within three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sensor_temp | input | 7 | Temperature sample, whole degrees Celsius |
| no_throttle_strap | input | 1 | Capability strap: 1 suppresses automatic throttling |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| throttle_level | output | 2 | 0 none, 1 50%, 2 90%, 3 100% |
| fatal_shutdown | output | 1 | Shutdown request to the board controller |

## Verification
A corrupted limit or enable shows up in two places. The affected alarm bit flips at the wrong temperature, and the throttle code steps at the wrong point of a rising sweep. Both are visible within three edges of the sensor reaching the faulty boundary. Every temperature is therefore swept under all combinations of enables, policy and trip setting, so each boundary is crossed. A bad policy or strap path changes the throttle code while the alarm bits stay correct, which separates selection faults from comparison faults. A decode error shows as nonzero data on an unmapped read, or as a changed limit register after a stray write.

// File: rtl/thermal_mon_pkg.sv
package thermal_mon_pkg;

    localparam int TEMP_W = 7;
    localparam int DATA_W = 64;

    localparam int WARN_LSB   = 0;
    localparam int WARN_EN    = 7;
    localparam int CRIT_LSB   = 8;
    localparam int CRIT_EN    = 15;
    localparam int TRIP_LSB   = 24;
    localparam int WARN_FLAG  = 32;
    localparam int CRIT_FLAG  = 33;
    localparam int POLICY_BIT = 44;

    typedef enum logic [1:0] {
        THR_NONE = 2'd0,
        THR_HALF = 2'd1,
        THR_MOST = 2'd2,
        THR_FULL = 2'd3
    } throttle_e;

    typedef struct packed {
        logic [TEMP_W-1:0] warn_lvl;
        logic              warn_en;
        logic [TEMP_W-1:0] crit_lvl;
        logic              crit_en;
        logic [TEMP_W-1:0] trip_lvl;
        logic              light_policy;
    } limits_t;

    typedef struct packed {
        logic warn_hit;
        logic crit_hit;
        logic trip_hit;
    } alarm_t;

    function automatic limits_t unpack_limits(input logic [DATA_W-1:0] w);
        limits_t l;
        l.warn_lvl     = w[WARN_LSB +: TEMP_W];
        l.warn_en      = w[WARN_EN];
        l.crit_lvl     = w[CRIT_LSB +: TEMP_W];
        l.crit_en      = w[CRIT_EN];
        l.trip_lvl     = w[TRIP_LSB +: TEMP_W];
        l.light_policy = w[POLICY_BIT];
        return l;
    endfunction

    function automatic logic [DATA_W-1:0] pack_limits(input limits_t l, input alarm_t a);
        logic [DATA_W-1:0] w;
        w = '0;
        w[WARN_LSB +: TEMP_W] = l.warn_lvl;
        w[WARN_EN]            = l.warn_en;
        w[CRIT_LSB +: TEMP_W] = l.crit_lvl;
        w[CRIT_EN]            = l.crit_en;
        w[TRIP_LSB +: TEMP_W] = l.trip_lvl;
        w[WARN_FLAG]          = a.warn_hit;
        w[CRIT_FLAG]          = a.crit_hit;
        w[POLICY_BIT]         = l.light_policy;
        return w;
    endfunction

    function automatic throttle_e pick_level(input alarm_t a, input logic light);
        if (a.crit_hit)      return THR_FULL;
        else if (a.warn_hit) return light ? THR_HALF : THR_MOST;
        else                 return THR_NONE;
    endfunction

endpackage

// File: rtl/thm_limit_regs.sv
module thm_limit_regs
    import thermal_mon_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int LIMIT_OFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output limits_t           limits
);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LIMIT_OFS);

    logic hit;
    assign hit = wr_en && (addr == LIMIT_A);

    always_ff @(posedge clk) begin
        if (rst)      limits <= '0;
        else if (hit) limits <= unpack_limits(wdata);
    end

    assert_stray_write_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != LIMIT_A) |=> $stable(limits));

endmodule

// File: rtl/thm_compare.sv
module thm_compare
    import thermal_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] sensor_in,
    input  limits_t           limits,
    output logic [TEMP_W-1:0] sample_q,
    output alarm_t            alarm_q
);
    alarm_t alarm_d;

    always_comb begin
        alarm_d.warn_hit = limits.warn_en && (sample_q >= limits.warn_lvl);
        alarm_d.crit_hit = limits.crit_en && (sample_q >= limits.crit_lvl);
        alarm_d.trip_hit = (limits.trip_lvl != '0) && (sample_q >= limits.trip_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            alarm_q  <= '0;
        end else begin
            sample_q <= sensor_in;
            alarm_q  <= alarm_d;
        end
    end

    assert_warn_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !limits.warn_en |=> !alarm_q.warn_hit);
    assert_crit_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !limits.crit_en |=> !alarm_q.crit_hit);
    assert_trip_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (limits.trip_lvl == '0) |=> !alarm_q.trip_hit);

endmodule

// File: rtl/thm_throttle.sv
module thm_throttle
    import thermal_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  alarm_t    alarm,
    input  logic      light_policy,
    input  logic      no_throttle,
    output throttle_e level_q,
    output logic      fatal_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= THR_NONE;
            fatal_q <= 1'b0;
        end else begin
            level_q <= no_throttle ? THR_NONE : pick_level(alarm, light_policy);
            fatal_q <= alarm.trip_hit;
        end
    end

    assert_crit_full_R4: assert property (@(posedge clk) disable iff (rst)
        (alarm.crit_hit && !no_throttle) |=> (level_q == THR_FULL));
    assert_light_policy_R5: assert property (@(posedge clk) disable iff (rst)
        (alarm.warn_hit && !alarm.crit_hit && !no_throttle && light_policy) |=> (level_q == THR_HALF));
    assert_strap_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        no_throttle |=> (level_q == THR_NONE));
    assert_fatal_follow_R7: assert property (@(posedge clk) disable iff (rst)
        alarm.trip_hit |=> fatal_q);

endmodule

// File: rtl/thermal_mon_top.sv
module thermal_mon_top
    import thermal_mon_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int LIMIT_OFS = 8,
    parameter int TEMP_OFS  = 16,
    parameter int CAP_OFS   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        sensor_temp,
    input  logic              no_throttle_strap,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic [1:0]        throttle_level,
    output logic              fatal_shutdown
);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LIMIT_OFS);
    localparam logic [ADDR_W-1:0] TEMP_A  = ADDR_W'(TEMP_OFS);
    localparam logic [ADDR_W-1:0] CAP_A   = ADDR_W'(CAP_OFS);

    limits_t           limits;
    alarm_t            alarm;
    logic [TEMP_W-1:0] sample;
    throttle_e         level;
    logic [DATA_W-1:0] rd_mux;

    thm_limit_regs #(.ADDR_W(ADDR_W), .LIMIT_OFS(LIMIT_OFS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .limits(limits)
    );

    thm_compare u_cmp (
        .clk(clk), .rst(rst), .sensor_in(sensor_temp), .limits(limits),
        .sample_q(sample), .alarm_q(alarm)
    );

    thm_throttle u_thr (
        .clk(clk), .rst(rst), .alarm(alarm), .light_policy(limits.light_policy),
        .no_throttle(no_throttle_strap), .level_q(level), .fatal_q(fatal_shutdown)
    );

    assign throttle_level = level;

    always_comb begin
        rd_mux = '0;
        if (reg_addr == LIMIT_A)     rd_mux = pack_limits(limits, alarm);
        else if (reg_addr == TEMP_A) rd_mux[TEMP_W-1:0] = sample;
        else if (reg_addr == CAP_A)  rd_mux[0] = no_throttle_strap;
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr != LIMIT_A && reg_addr != TEMP_A && reg_addr != CAP_A)
        |=> (reg_rdata == '0));

endmodule

// File: tb/test_thermal_mon_top.sv
module test_thermal_mon_top;

    logic        clk = 0;
    logic        rst = 1;
    logic [6:0]  sensor_temp = 0;
    logic        no_throttle_strap = 0;
    logic        reg_wr = 0;
    logic        reg_rd = 0;
    logic [5:0]  reg_addr = 0;
    logic [63:0] reg_wdata = 0;
    logic [63:0] reg_rdata;
    logic [1:0]  throttle_level;
    logic        fatal_shutdown;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #5 clk = ~clk;

    thermal_mon_top i_thermal_mon_top (
        .clk(clk), .rst(rst), .sensor_temp(sensor_temp),
        .no_throttle_strap(no_throttle_strap), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .throttle_level(throttle_level), .fatal_shutdown(fatal_shutdown)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [63:0] lim_word(input logic [6:0] t1, input logic e1,
            input logic [6:0] t2, input logic e2, input logic [6:0] tr,
            input logic s1, input logic s2, input logic pol);
        return {19'b0, pol, 10'b0, s2, s1, 1'b0, tr, 8'b0, e2, t2, e1, t1};
    endfunction

    initial begin
        #1500000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd(6'h08, d); check("R1 limit reg", d, 64'h0);
        check("R1 throttle", {62'b0, throttle_level}, 64'h0);
        check("R1 fatal", {63'b0, fatal_shutdown}, 64'h0);

        // R2 writable fields; status and reserved bits ignored
        wr(6'h08, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(6'h08, d);
        check("R2 all-ones write", d, lim_word(7'h7F,1,7'h7F,1,7'h7F,0,0,1));
        wr(6'h08, 64'hA5A5_A5A5_A5A5_A5A5);
        rd(6'h08, d);
        check("R2 pattern write", d, lim_word(7'h25,1,7'h25,1,7'h25,0,0,0));

        // R11 stray writes and unmapped reads
        wr(6'h10, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(6'h20, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(6'h09, 64'h0);
        rd(6'h08, d);
        check("R11 stray writes", d, lim_word(7'h25,1,7'h25,1,7'h25,0,0,0));
        for (int a = 0; a < 64; a++) begin
            if (a != 8 && a != 16 && a != 32) begin
                rd(6'(a), d);
                check("R11 unmapped read", d, 64'h0);
            end
        end

        // R9 sensor readout sweep
        for (int t = 0; t < 128; t += 9) begin
            @(negedge clk); sensor_temp = 7'(t);
            settle();
            rd(6'h10, d);
            check("R9 readout", d, 64'(t));
        end

        // Exhaustive temperature sweep over enables, policy and trip setting
        for (int c = 0; c < 16; c++) begin
            logic e1, e2, pol;
            logic [6:0] tr;
            e1 = c[0]; e2 = c[1]; pol = c[2];
            tr = c[3] ? 7'd0 : 7'd100;
            wr(6'h08, lim_word(7'd40, e1, 7'd80, e2, tr, 0, 0, pol));
            for (int t = 0; t < 128; t++) begin
                logic s1, s2, f;
                logic [1:0] lv;
                @(negedge clk); sensor_temp = 7'(t);
                settle();
                s1 = e1 && (t >= 40);
                s2 = e2 && (t >= 80);
                f  = (tr != 0) && (t >= tr);
                lv = s2 ? 2'd3 : (s1 ? (pol ? 2'd1 : 2'd2) : 2'd0);
                if (s2) check("R4 full throttle", {62'b0, throttle_level}, {62'b0, lv});
                else if (!e1 && !e2) check("R6 disabled no throttle", {62'b0, throttle_level}, 64'h0);
                else check("R5 policy level", {62'b0, throttle_level}, {62'b0, lv});
                if (tr == 0) check("R8 trip zero", {63'b0, fatal_shutdown}, 64'h0);
                else check("R7 fatal", {63'b0, fatal_shutdown}, {63'b0, f});
                if (t % 4 == 0 || t == 39 || t == 79 || t == 99) begin
                    rd(6'h08, d);
                    check("R3 alarm bits", d, lim_word(7'd40, e1, 7'd80, e2, tr, s1, s2, pol));
                end
            end
        end

        // R10 strap suppresses throttling, alarms and fatal unaffected
        @(negedge clk); no_throttle_strap = 1;
        rd(6'h20, d); check("R10 capability bit", d, 64'h1);
        wr(6'h08, lim_word(7'd40, 1, 7'd80, 1, 7'd100, 0, 0, 0));
        for (int t = 0; t < 128; t += 3) begin
            @(negedge clk); sensor_temp = 7'(t);
            settle();
            check("R10 strap throttle", {62'b0, throttle_level}, 64'h0);
            check("R10 strap fatal", {63'b0, fatal_shutdown}, {63'b0, (t >= 100)});
            rd(6'h08, d);
            check("R10 strap alarms", d, lim_word(7'd40,1,7'd80,1,7'd100,(t>=40),(t>=80),0));
        end
        @(negedge clk); no_throttle_strap = 0;
        rd(6'h20, d); check("R10 capability clear", d, 64'h0);

        // R12 latency: sensor to throttle within three edges, not earlier than three
        @(negedge clk); sensor_temp = 7'd0;
        settle();
        @(negedge clk); sensor_temp = 7'd90;
        @(negedge clk); @(negedge clk);
        check("R12 not yet", {62'b0, throttle_level}, 64'h0);
        @(negedge clk);
        check("R12 third edge", {62'b0, throttle_level}, 64'h3);

        // R1 reset clears programmed state
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd(6'h08, d); check("R1 after reset", d, 64'h0);
        check("R1 throttle after reset", {62'b0, throttle_level}, 64'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule